// File: doc/BRIEF.md
# Dual Counter/Timer with Split Mode

This block holds two general-purpose counter/timers, timer A (index 0) and timer B (index 1). Each one counts a time base or falling edges on an external pin, and each can be gated by an active-low level input. A byte-wide register port gives access to a mode register, a control/status register and the four counter bytes. Each timer has four modes: a 13-bit counter, a 16-bit counter, an 8-bit counter that reloads itself, and a split mode.

In split mode, timer A becomes two independent 8-bit counters. The low byte keeps timer A's own controls and flag. The high byte counts only the time base, and it borrows timer B's run bit and overflow flag. While timer A is split, timer B runs on its time base without control. It never raises its flag, and it still emits its overflow pulse for a downstream baud-rate generator. Putting timer B itself into split mode halts it.

The overflow flags go to an interrupt controller, and the overflow pulse goes to a serial-port rate generator. Neither of those is part of this block.

Top module: `dtmr_top`

## Requirements
- R1: After reset, every register reads 0x00, both overflow flags are 0 and `baud_tick` is 0.
- R2: The register addresses are as follows: 0 is the mode register, 1 is the control register, 2 and 3 are the low and high bytes of timer A, and 4 and 5 are the low and high bytes of timer B. The mode register is read/write. Its bits from MSB to LSB are gate B, count-select B, mode B[1:0], gate A, count-select A, mode A[1:0]. The control register reads, from MSB to LSB, flag B, run B, flag A, run A, and then four bits that always read 0. A counter byte reads back the value last written while its timer is stopped.
- R3: Mode 1 is a 16-bit up-counter made of {high, low}. It wraps from 0xFFFF to 0x0000, and the wrap sets the timer's flag.
- R4: Mode 0 is a 13-bit counter made of the high byte and low[4:0]. Low bits [7:5] keep their value. Overflow occurs when high is 0xFF and low[4:0] is 0x1F, and it sets the flag.
- R5: In mode 2 the low byte counts. On the step from 0xFF it loads the high byte instead of wrapping, and it sets the flag. The high byte does not change.
- R6: When `presc_sel[i]` is 1, the time base of timer i steps once every 12 clocks. When it is 0, the time base steps on every clock.
- R7: A timer that is not split counts only while its run bit is 1 and either its gate bit is 0 or its `gate_n` pin (after synchronisation) is high.
- R8: When count-select is 1, the timer counts falling edges on its `ext_cnt` pin after a two-flop synchroniser, at most one step per clock. The time base is not used in this case.
- R9: With mode A = 3, the low byte of timer A is run by run A, gate A and count-select A, and sets flag A on its wrap from 0xFF. The high byte of timer A counts timer A's time base while run B is 1, and sets flag B on its wrap from 0xFF.
- R10: With mode B = 3, timer B does not count, whatever its run bit is.
- R11: With mode A = 3 and mode B not 3, timer B counts its time base on every step, ignoring run B, gate B and count-select B. Its overflows never set flag B.
- R12: A write to the control register sets or clears both flags. A hardware overflow in the same cycle sets the flag regardless of the written value.
- R13: Every overflow of timer B in modes 0, 1 or 2 raises `baud_tick` for one clock, in the cycle after the edge at which it wraps. This holds whether or not timer A is split.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| presc_sel | input | 2 | Per-timer time base select: 1 = clock/12, 0 = clock |
| ext_cnt | input | 2 | External count pins (asynchronous) |
| gate_n | input | 2 | Active-low gate pins (asynchronous) |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address |
| wr_data | input | 8 | Write data |
| rd_addr | input | 3 | Read address |
| rd_data | output | 8 | Read data, combinational from registers |
| ovf_flag | output | 2 | Overflow flags {B, A} |
| baud_tick | output | 1 | One-clock pulse on each timer B overflow |

## Verification
Some properties are checked on every cycle:
- an overflow of timer A always raises flag A;
- the mode 2 reload copies the high byte;
- a halted timer B holds both of its bytes;
- while timer A is split, timer B's overflow leaves flag B untouched;
- the prescaler stays in range;
- the edge detector never fires twice in a row.

The bench scenarios cover the rest:
- exact count values in the 13-bit, 16-bit and reload modes;
- the one-in-twelve time base;
- gating;
- external edge counting;
- the borrowed run bit and flag in split mode;
- the number of baud pulses against the number of overflows in the model;
- priority of an overflow over a flag write in the same cycle.

// File: rtl/dtmr_pkg.sv
package dtmr_pkg;
    localparam int DW = 8;
    localparam int AW = 3;

    typedef enum logic [1:0] {
        M_PRE13 = 2'd0,
        M_FULL16 = 2'd1,
        M_RELOAD8 = 2'd2,
        M_SPLIT = 2'd3
    } tmode_e;

    localparam logic [AW-1:0] A_MODE = 3'd0;
    localparam logic [AW-1:0] A_CTRL = 3'd1;
    localparam logic [AW-1:0] A_LO0  = 3'd2;
    localparam logic [AW-1:0] A_HI0  = 3'd3;
    localparam logic [AW-1:0] A_LO1  = 3'd4;
    localparam logic [AW-1:0] A_HI1  = 3'd5;

    typedef struct packed {
        logic [DW-1:0] mode;
        logic [1:0]    run;
        logic [1:0]    flag;
        logic [DW-1:0] lo0;
        logic [DW-1:0] hi0;
        logic [DW-1:0] lo1;
        logic [DW-1:0] hi1;
        logic          baud;
    } dtmr_state_t;
endpackage

// File: rtl/dtmr_presc.sv
module dtmr_presc #(
    parameter int DIV = 12
) (
    input  logic clk,
    input  logic rst_n,
    output logic stb
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
        stb   = (cnt_q == LAST);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    AST_DIV_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST); // R6
endmodule

// File: rtl/dtmr_sync.sv
module dtmr_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ext_in,
    input  logic gate_in_n,
    output logic ext_fall,
    output logic gate_hi
);
    logic [STAGES:0]   esh_d, esh_q;
    logic [STAGES-1:0] gsh_d, gsh_q;

    always_comb begin
        esh_d    = {esh_q[STAGES-1:0], ext_in};
        gsh_d    = {gsh_q[STAGES-2:0], gate_in_n};
        ext_fall = esh_q[STAGES] & ~esh_q[STAGES-1];
        gate_hi  = gsh_q[STAGES-1];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            esh_q <= '1;
            gsh_q <= '1;
        end else begin
            esh_q <= esh_d;
            gsh_q <= gsh_d;
        end
    end

    AST_ONE_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        ext_fall |=> !ext_fall); // R8
endmodule

// File: rtl/dtmr_step.sv
module dtmr_step
    import dtmr_pkg::*;
#(
    parameter int PRE_BITS = 5
) (
    input  tmode_e        mode,
    input  logic [DW-1:0] lo,
    input  logic [DW-1:0] hi,
    input  logic          inc,
    output logic [DW-1:0] lo_nx,
    output logic [DW-1:0] hi_nx,
    output logic          ovf
);
    localparam logic [PRE_BITS-1:0] PRE_MAX = '1;
    localparam logic [DW-1:0]       BYTE_MAX = '1;

    logic [2*DW-1:0] wide;

    always_comb begin
        lo_nx = lo;
        hi_nx = hi;
        ovf   = 1'b0;
        wide  = {hi, lo} + 1'b1;
        if (inc) begin
            case (mode)
                M_PRE13: begin
                    lo_nx[PRE_BITS-1:0] = lo[PRE_BITS-1:0] + 1'b1;
                    if (lo[PRE_BITS-1:0] == PRE_MAX) begin
                        hi_nx = hi + 1'b1;
                        ovf   = (hi == BYTE_MAX);
                    end
                end
                M_FULL16: begin
                    {hi_nx, lo_nx} = wide;
                    ovf = ({hi, lo} == {BYTE_MAX, BYTE_MAX});
                end
                M_RELOAD8: begin
                    if (lo == BYTE_MAX) begin
                        lo_nx = hi;
                        ovf   = 1'b1;
                    end else begin
                        lo_nx = lo + 1'b1;
                    end
                end
                default: begin
                    lo_nx = lo + 1'b1;
                    ovf   = (lo == BYTE_MAX);
                end
            endcase
        end
    end
endmodule

// File: rtl/dtmr_top.sv
module dtmr_top
    import dtmr_pkg::*;
#(
    parameter int PRESC_DIV = 12,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    presc_sel,
    input  logic [1:0]    ext_cnt,
    input  logic [1:0]    gate_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data,
    output logic [1:0]    ovf_flag,
    output logic          baud_tick
);
    localparam logic [DW-1:0] BYTE_MAX = '1;

    dtmr_state_t s_d, s_q;

    logic          div_stb;
    logic [1:0]    fall, gate_ok, tick;
    logic [1:0]    inc;
    tmode_e        md0, md1;
    logic [DW-1:0] lo0_nx, hi0_nx, lo1_nx, hi1_nx;
    logic          ovf0, ovf1;
    logic          t0_split, t1_halt, inc_h, ovf_h;
    logic          wr_ctrl;

    dtmr_presc #(.DIV(PRESC_DIV)) u_presc (
        .clk(clk), .rst_n(rst_n), .stb(div_stb)
    );

    for (genvar i = 0; i < 2; i++) begin : g_pin
        dtmr_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk(clk), .rst_n(rst_n),
            .ext_in(ext_cnt[i]), .gate_in_n(gate_n[i]),
            .ext_fall(fall[i]), .gate_hi(gate_ok[i])
        );
        assign tick[i] = presc_sel[i] ? div_stb : 1'b1;
    end

    always_comb begin
        md0      = tmode_e'(s_q.mode[1:0]);
        md1      = tmode_e'(s_q.mode[5:4]);
        t0_split = (md0 == M_SPLIT);
        t1_halt  = (md1 == M_SPLIT);

        inc[0] = s_q.run[0] & (~s_q.mode[3] | gate_ok[0])
               & (s_q.mode[2] ? fall[0] : tick[0]);

        if (t1_halt)
            inc[1] = 1'b0;
        else if (t0_split)
            inc[1] = tick[1];
        else
            inc[1] = s_q.run[1] & (~s_q.mode[7] | gate_ok[1])
                   & (s_q.mode[6] ? fall[1] : tick[1]);

        inc_h = t0_split & s_q.run[1] & tick[0];
        ovf_h = inc_h & (s_q.hi0 == BYTE_MAX);
    end

    dtmr_step u_step0 (
        .mode(md0), .lo(s_q.lo0), .hi(s_q.hi0), .inc(inc[0]),
        .lo_nx(lo0_nx), .hi_nx(hi0_nx), .ovf(ovf0)
    );

    dtmr_step u_step1 (
        .mode(md1), .lo(s_q.lo1), .hi(s_q.hi1), .inc(inc[1]),
        .lo_nx(lo1_nx), .hi_nx(hi1_nx), .ovf(ovf1)
    );

    always_comb begin
        s_d     = s_q;
        wr_ctrl = wr_en && (wr_addr == A_CTRL);

        s_d.lo0 = lo0_nx;
        s_d.hi0 = t0_split ? (s_q.hi0 + DW'(inc_h)) : hi0_nx;
        s_d.lo1 = lo1_nx;
        s_d.hi1 = hi1_nx;

        if (wr_ctrl) begin
            s_d.flag = {wr_data[7], wr_data[5]};
            s_d.run  = {wr_data[6], wr_data[4]};
        end
        if (ovf0)
            s_d.flag[0] = 1'b1;
        if (ovf_h || (ovf1 && !t0_split))
            s_d.flag[1] = 1'b1;

        s_d.baud = ovf1;

        if (wr_en) begin
            case (wr_addr)
                A_MODE: s_d.mode = wr_data;
                A_LO0:  s_d.lo0  = wr_data;
                A_HI0:  s_d.hi0  = wr_data;
                A_LO1:  s_d.lo1  = wr_data;
                A_HI1:  s_d.hi1  = wr_data;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_comb begin
        case (rd_addr)
            A_MODE:  rd_data = s_q.mode;
            A_CTRL:  rd_data = {s_q.flag[1], s_q.run[1], s_q.flag[0], s_q.run[0], 4'b0000};
            A_LO0:   rd_data = s_q.lo0;
            A_HI0:   rd_data = s_q.hi0;
            A_LO1:   rd_data = s_q.lo1;
            A_HI1:   rd_data = s_q.hi1;
            default: rd_data = '0;
        endcase
        ovf_flag  = s_q.flag;
        baud_tick = s_q.baud;
    end

    AST_OVF_FLAG0: assert property (@(posedge clk) disable iff (!rst_n)
        ovf0 |=> s_q.flag[0]); // R12

    AST_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (md0 == M_RELOAD8 && ovf0 && !wr_en) |=> (s_q.lo0 == $past(s_q.hi0))); // R5

    AST_T1_HALT: assert property (@(posedge clk) disable iff (!rst_n)
        (t1_halt && !(wr_en && (wr_addr == A_LO1 || wr_addr == A_HI1)))
        |=> ($stable(s_q.lo1) && $stable(s_q.hi1))); // R10

    AST_T1_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (t0_split && ovf1 && !ovf_h && !wr_ctrl) |=> $stable(s_q.flag[1])); // R11
endmodule

// File: tb/sim_dtmr_top.sv
module sim_dtmr_top;
    localparam time HALF = 10ns;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] presc_sel = 2'b00;
    logic [1:0] ext_cnt = 2'b11;
    logic [1:0] gate_n = 2'b11;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [2:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic [1:0] ovf_flag;
    logic       baud_tick;

    int total = 0;
    int bad = 0;
    int baud_cnt = 0;

    always #(HALF) clk = ~clk;

    dtmr_top u0 (
        .clk(clk), .rst_n(rst_n), .presc_sel(presc_sel), .ext_cnt(ext_cnt),
        .gate_n(gate_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .ovf_flag(ovf_flag), .baud_tick(baud_tick)
    );

    always @(negedge clk) if (baud_tick) baud_cnt++;

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        rd_addr = a; #1;
        d = rd_data;
    endtask

    // start with ctrl value, count for exactly n steps, then stop keeping flags
    task automatic run_for(input logic [7:0] ctrl, input int n);
        logic [7:0] c;
        wr(3'd1, ctrl);
        repeat (n - 1) @(posedge clk);
        @(negedge clk);
        rd_addr = 3'd1; #1;
        c = rd_data;
        wr_en = 1'b1; wr_addr = 3'd1; wr_data = {c[7], 1'b0, c[5], 5'b0};
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    // model: returns {ovf_count[15:0], hi, lo}
    function automatic logic [31:0] model(input int m, input logic [7:0] lo,
                                          input logic [7:0] hi, input int n);
        int ov = 0;
        for (int k = 0; k < n; k++) begin
            case (m)
                0: begin
                    if (lo[4:0] == 5'h1f) begin
                        if (hi == 8'hff) ov++;
                        hi = hi + 1;
                    end
                    lo[4:0] = lo[4:0] + 1;
                end
                1: begin
                    if ({hi, lo} == 16'hffff) ov++;
                    {hi, lo} = {hi, lo} + 16'd1;
                end
                default: begin
                    if (lo == 8'hff) begin lo = hi; ov++; end
                    else lo = lo + 1;
                end
            endcase
        end
        return {ov[15:0], hi, lo};
    endfunction

    initial begin
        #(HALF * 2 * 200000);
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [7:0] v, lo, hi, c;
        logic [31:0] e;
        void'($urandom(32'd4242));
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        for (int a = 0; a < 6; a++) begin
            rd(3'(a), v);
            chk("R1 reg", v, 0);
        end
        chk("R1 flags", ovf_flag, 0);
        chk("R1 baud", baud_cnt, 0);

        // R2 register map read back
        wr(3'd0, 8'hA6); rd(3'd0, v); chk("R2 mode", v, 8'hA6);
        wr(3'd1, 8'hAF); rd(3'd1, v); chk("R2 ctrl low bits zero", v, 8'hA0);
        chk("R2 flags out", ovf_flag, 2'b11);
        wr(3'd1, 8'h00);
        wr(3'd0, 8'h00);
        for (int a = 2; a < 6; a++) begin
            wr(3'(a), 8'h30 + 8'(a));
            rd(3'(a), v);
            chk("R2 byte", v, 8'h30 + a);
        end

        // R3 16-bit mode with wrap
        wr(3'd0, 8'h01); wr(3'd2, 8'hF0); wr(3'd3, 8'hFF);
        run_for(8'h10, 20);
        rd(3'd2, lo); rd(3'd3, hi);
        chk("R3 16bit", {hi, lo}, 16'h0004);
        chk("R3 flag", ovf_flag[0], 1);

        // R4 13-bit mode
        wr(3'd1, 8'h00);
        wr(3'd0, 8'h00); wr(3'd2, 8'hFC); wr(3'd3, 8'hFF);
        run_for(8'h10, 5);
        rd(3'd2, lo); rd(3'd3, hi);
        chk("R4 13bit", {hi, lo}, 16'h00E1);
        chk("R4 flag", ovf_flag[0], 1);

        // R5 reload
        wr(3'd1, 8'h00);
        wr(3'd0, 8'h02); wr(3'd2, 8'hFE); wr(3'd3, 8'h80);
        run_for(8'h10, 5);
        rd(3'd2, lo); rd(3'd3, hi);
        chk("R5 reload", {hi, lo}, 16'h8083);
        chk("R5 flag", ovf_flag[0], 1);

        // R6 prescale
        wr(3'd1, 8'h00);
        presc_sel = 2'b01;
        wr(3'd0, 8'h01); wr(3'd2, 8'h00); wr(3'd3, 8'h00);
        run_for(8'h10, 120);
        rd(3'd2, lo);
        chk("R6 div12", lo, 10);
        presc_sel = 2'b00;

        // R7 gating
        wr(3'd0, 8'h09); wr(3'd2, 8'h00);
        gate_n[0] = 1'b0;
        repeat (4) @(posedge clk);
        run_for(8'h10, 50);
        rd(3'd2, lo);
        chk("R7 gated off", lo, 0);
        gate_n[0] = 1'b1;
        repeat (4) @(posedge clk);
        run_for(8'h10, 50);
        rd(3'd2, lo);
        chk("R7 gate open", lo, 50);

        // R8 external edges
        wr(3'd0, 8'h05); wr(3'd2, 8'h00); wr(3'd3, 8'h00);
        wr(3'd1, 8'h10);
        for (int k = 0; k < 7; k++) begin
            @(negedge clk) ext_cnt[0] = 1'b0;
            repeat (3) @(negedge clk);
            ext_cnt[0] = 1'b1;
            repeat (2) @(negedge clk);
        end
        repeat (5) @(posedge clk);
        wr(3'd1, 8'h00);
        rd(3'd2, lo);
        chk("R8 ext edges", lo, 7);

        // R9 split mode, timer B halted (R10)
        wr(3'd0, 8'h33);
        wr(3'd2, 8'hF0); wr(3'd3, 8'hFA); wr(3'd4, 8'h11); wr(3'd5, 8'h22);
        run_for(8'h50, 20);
        rd(3'd2, lo); chk("R9 low byte", lo, 8'h04);
        rd(3'd3, hi); chk("R9 high byte", hi, 8'h0E);
        chk("R9 flags", ovf_flag, 2'b11);
        rd(3'd4, lo); rd(3'd5, hi);
        chk("R10 halted", {hi, lo}, 16'h2211);

        // R9 high byte idle without run B
        wr(3'd1, 8'h00);
        wr(3'd3, 8'h40);
        run_for(8'h10, 10);
        rd(3'd3, hi);
        chk("R9 high needs run B", hi, 8'h40);

        // R11 timer B free-running while A split, no flag, baud pulses
        wr(3'd1, 8'h00);
        wr(3'd0, 8'h11);
        wr(3'd4, 8'hF0); wr(3'd5, 8'hFF);
        baud_cnt = 0;
        wr(3'd0, 8'h53);
        repeat (39) @(posedge clk);
        wr(3'd0, 8'h33);
        rd(3'd4, lo); rd(3'd5, hi);
        chk("R11 count", {hi, lo}, 16'h0018);
        chk("R11 no flag", ovf_flag[1], 0);
        chk("R13 baud in split", baud_cnt, 1);

        // R12 flag write and overflow priority
        wr(3'd1, 8'h20); chk("R12 set", ovf_flag, 2'b01);
        wr(3'd1, 8'h00); chk("R12 clear", ovf_flag, 2'b00);
        wr(3'd0, 8'h01); wr(3'd2, 8'hFF); wr(3'd3, 8'hFF);
        wr(3'd1, 8'h10);
        wr(3'd1, 8'h10);
        chk("R12 hw wins", ovf_flag[0], 1);
        wr(3'd1, 8'h00);

        // R3 R4 R5 R13 random on timer B
        for (int it = 0; it < 8; it++) begin
            int m, n;
            m  = int'($urandom_range(2, 0));
            n  = int'($urandom_range(400, 1));
            lo = 8'($urandom);
            hi = 8'($urandom);
            if (it < 3) hi = 8'hFF;
            e = model(m, lo, hi, n);
            wr(3'd0, 8'(m << 4));
            wr(3'd4, lo); wr(3'd5, hi);
            wr(3'd1, 8'h00);
            baud_cnt = 0;
            run_for(8'h40, n);
            repeat (2) @(posedge clk);
            rd(3'd4, lo); rd(3'd5, hi);
            chk("R3 R4 R5 random count", {hi, lo}, e[15:0]);
            chk("R13 baud count", baud_cnt, int'(e[31:16]));
            rd(3'd1, c);
            chk("R12 flag B", c[7], (e[31:16] != 0));
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule